// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupt Summary

The block is a bank of general-purpose pins behind a simple 32-bit register port. Each pin has its own 32-bit word at byte offset N*4. That word drives the pin's output value and output enable. It shows the synchronised input level. It also sets up interrupt detection: level or edge, the polarity, a detect enable and a forward mask. A sticky status bit in the same word records a detected event.

Pending events (status set and forwarded) are folded into a summary with one bit per group of four pins. The summary spans two 32-bit words. A single level interrupt line goes to the host. It latches high once anything is pending and stays high until the host writes the end-of-interrupt bit in the master register. After that write the line drops for one cycle and then follows the summary again.

The host handler reads the summary words, visits the four pin words of each flagged group, and clears each status by writing it back with the status bit set. It finishes with the end-of-interrupt write. Pin index 63 has no register of its own, because its slot holds the master register. The parameter NPINS must lie between 64 and 184.

Top module: `gpio_bank_top`

## Requirements
- R1: After reset, pin_out, pin_oe and irq are 0, and every pin word, both summary words and the master word read as 0 while all inputs are low.
- R2: A write to pin word N stores bit 22 (output value), bit 23 (output enable), bit 8 (level mode), bits 10:9 (polarity), bit 11 (detect enable) and bit 12 (forward mask). These read back at the same positions, and pin_out[N]/pin_oe[N] follow bits 22/23 from the cycle after the write.
- R3: Bit 16 of pin word N shows pin_in[N] through a two-flop synchroniser. A change driven before clock edge k becomes readable after edge k+1.
- R4: With bit 8 = 0 and detect enable set, polarity 00 sets status bit 28 on a rising edge only, bit 9 set selects falling edges only, and bit 10 set selects both edges. The status is set on the clock edge after the edge is visible in bit 16.
- R5: With bit 8 = 1, bit 9 = 0 flags a high input and bit 9 = 1 flags a low input. A cleared status is set again one cycle later while the active level persists.
- R6: Status bit 28 is write-1-to-clear: writing the word with bit 28 = 0 leaves it set. Writes to bit 16 and to unused bits are ignored, and unused bits and unmapped offsets read 0.
- R7: Offset 0xFC is the master register and reads 0. A write there configures no pin, and pin 63 never raises status, summary or irq whatever its input does.
- R8: Status sets only while bit 11 is 1, and it reaches the summary only while bit 12 is 1. Summary bit i (pins 4i..4i+3) reads at offset 0x2F8 bit i for i < 32 and at 0x2FC bit i-32 otherwise. irq rises on the edge after a summary bit appears.
- R9: Once high, irq stays high, even after all status is cleared, until a write to 0xFC with bit 29 set. irq is then 0 for one cycle and afterwards rises again if anything is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NPINS | Raw pin input levels |
| pin_out | output | NPINS | Output values |
| pin_oe | output | NPINS | Output driver enables |
| irq | output | 1 | Host interrupt line, active high |

## Verification
The hardest situation to reach is the re-arm window. irq must hold high with no status pending, and an end-of-interrupt must come while status is still pending, so that the one-cycle drop and the rise back can both be seen. The stimulus raises an edge event, issues end-of-interrupt without clearing it, and then clears the status before a second end-of-interrupt. Each step is sampled on exact cycles that are counted through the synchroniser, detector and line register. Level-mode re-set after a clear is checked the same way, one read right after the clearing write and one read a cycle later.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W     = 32;
    localparam int RSVD_PIN   = 63;   // slot taken by the master register
    localparam int MASTER_IDX = 63;   // byte offset 0xFC
    localparam int SUM_LO_IDX = 190;  // byte offset 0x2F8
    localparam int SUM_HI_IDX = 191;  // byte offset 0x2FC

    localparam int B_LVL  = 8;
    localparam int B_POL0 = 9;
    localparam int B_POL1 = 10;
    localparam int B_DEN  = 11;
    localparam int B_FWD  = 12;
    localparam int B_IN   = 16;
    localparam int B_OVAL = 22;
    localparam int B_OEN  = 23;
    localparam int B_STS  = 28;
    localparam int B_EOI  = 29;

    typedef struct packed {
        logic       out_en;
        logic       out_val;
        logic       fwd;
        logic       det_en;
        logic [1:0] pol;
        logic       lvl_mode;
    } pin_cfg_t;

    function automatic pin_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        pin_cfg_t c;
        c.out_en   = w[B_OEN];
        c.out_val  = w[B_OVAL];
        c.fwd      = w[B_FWD];
        c.det_en   = w[B_DEN];
        c.pol      = {w[B_POL1], w[B_POL0]};
        c.lvl_mode = w[B_LVL];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] word_from_state(input pin_cfg_t c,
                                                          input logic sts,
                                                          input logic lvl_in);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[B_OEN]   = c.out_en;
        w[B_OVAL]  = c.out_val;
        w[B_FWD]   = c.fwd;
        w[B_DEN]   = c.det_en;
        w[B_POL1]  = c.pol[1];
        w[B_POL0]  = c.pol[0];
        w[B_LVL]   = c.lvl_mode;
        w[B_STS]   = sts;
        w[B_IN]    = lvl_in;
        return w;
    endfunction

    function automatic logic event_seen(input pin_cfg_t c,
                                        input logic cur, input logic prev);
        logic r;
        if (c.lvl_mode)
            r = c.pol[0] ? ~cur : cur;
        else if (c.pol[1])
            r = cur ^ prev;
        else if (c.pol[0])
            r = ~cur & prev;
        else
            r = cur & ~prev;
        return r;
    endfunction

endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pad_in,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word_o,
    output logic              out_o,
    output logic              oe_o,
    output logic              pend_o
);
    logic     sync1, sync2, prev;
    pin_cfg_t cfg;
    logic     sts;
    logic     hit;
    logic     unused_wd;

    assign unused_wd = ^{wdata[31:29], wdata[27:24], wdata[21:13], wdata[7:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= pad_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign hit = cfg.det_en && event_seen(cfg, sync2, prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            sts <= 1'b0;
        end else begin
            if (wr_sel)
                cfg <= cfg_from_word(wdata);
            if (wr_sel && wdata[B_STS])
                sts <= 1'b0;
            else if (hit)
                sts <= 1'b1;
        end
    end

    assign word_o = word_from_state(cfg, sts, sync2);
    assign out_o  = cfg.out_val;
    assign oe_o   = cfg.out_en;
    assign pend_o = sts && cfg.fwd;
endmodule

// File: rtl/gpio_group_summary.sv
module gpio_group_summary #(
    parameter int NPINS = 184
) (
    input  logic [NPINS-1:0] pend,
    output logic [63:0]      sum
);
    localparam int NGRP = (NPINS + 3) / 4;

    for (genvar g = 0; g < 64; g++) begin : g_grp
        if (g < NGRP) begin : g_used
            localparam int LO = 4 * g;
            localparam int HI = (4 * g + 3 < NPINS) ? 4 * g + 3 : NPINS - 1;
            assign sum[g] = |pend[HI:LO];
        end else begin : g_none
            assign sum[g] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_host_line.sv
module gpio_host_line (
    input  logic clk,
    input  logic rst,
    input  logic any_pend,
    input  logic eoi,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else if (eoi)
            irq <= 1'b0;
        else if (any_pend)
            irq <= 1'b1;
    end
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NPINS  = 184
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] NPIN_L   = IDX_W'(NPINS);
    localparam logic [IDX_W-1:0] RSVD_L   = IDX_W'(RSVD_PIN);
    localparam logic [IDX_W-1:0] MASTER_L = IDX_W'(MASTER_IDX);
    localparam logic [IDX_W-1:0] SUMLO_L  = IDX_W'(SUM_LO_IDX);
    localparam logic [IDX_W-1:0] SUMHI_L  = IDX_W'(SUM_HI_IDX);

    logic [IDX_W-1:0]  reg_idx;
    logic [WORD_W-1:0] pin_words [NPINS];
    logic [NPINS-1:0]  pin_pend;
    logic [63:0]       sum;
    logic              any_pend;
    logic              eoi;
    logic              rsvd_pend;
    logic              unused_addr;

    assign reg_idx     = bus_addr[ADDR_W-1:2];
    assign unused_addr = ^bus_addr[1:0];
    assign eoi         = bus_wr && (reg_idx == MASTER_L) && bus_wdata[B_EOI];

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic sel;
        assign sel = bus_wr && (reg_idx == IDX_W'(i)) && (i != RSVD_PIN);
        gpio_pin_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .pad_in (pin_in[i]),
            .wr_sel (sel),
            .wdata  (bus_wdata),
            .word_o (pin_words[i]),
            .out_o  (pin_out[i]),
            .oe_o   (pin_oe[i]),
            .pend_o (pin_pend[i])
        );
    end

    assign rsvd_pend = pin_pend[RSVD_PIN];

    gpio_group_summary #(.NPINS(NPINS)) u_sum (
        .pend (pin_pend),
        .sum  (sum)
    );

    assign any_pend = |sum;

    gpio_host_line u_line (
        .clk      (clk),
        .rst      (rst),
        .any_pend (any_pend),
        .eoi      (eoi),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (reg_idx == SUMLO_L)
            bus_rdata = sum[31:0];
        else if (reg_idx == SUMHI_L)
            bus_rdata = sum[63:32];
        else if (reg_idx < NPIN_L && reg_idx != RSVD_L)
            bus_rdata = pin_words[reg_idx];
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              wd_oval,
    input logic              wd_eoi,
    input logic              out0,
    input logic              irq,
    input logic              any_pend,
    input logic              rsvd_pend
);
    logic [ADDR_W-3:0] idx;
    logic              eoi_w;
    logic              unused_lo;

    assign idx       = bus_addr[ADDR_W-1:2];
    assign unused_lo = ^bus_addr[1:0];
    assign eoi_w     = bus_wr && (idx == (ADDR_W-2)'(63)) && wd_eoi;

    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (rst)
        !rsvd_pend);                                                 // R7
    AST_OUT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && idx == '0) |=> (out0 == $past(wd_oval)));         // R2
    AST_EOI_DROP: assert property (@(posedge clk) disable iff (rst)
        eoi_w |=> !irq);                                             // R9
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !eoi_w) |=> irq);                                    // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(any_pend));                             // R8
endmodule

bind gpio_bank_top gpio_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .wd_oval   (bus_wdata[22]),
    .wd_eoi    (bus_wdata[29]),
    .out0      (pin_out[0]),
    .irq       (irq),
    .any_pend  (any_pend),
    .rsvd_pend (rsvd_pend)
);

// File: tb/tb_gpio_bank_top.sv
module tb_gpio_bank_top;
    localparam int AW = 10;
    localparam int NP = 184;
    localparam logic [31:0] CFG_MASK = 32'h00C0_1F00;
    localparam logic [31:0] STS = 32'h1000_0000;
    localparam logic [31:0] EOI = 32'h2000_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int total = 0;
    int fails = 0;

    gpio_bank_top #(.ADDR_W(AW), .NPINS(NP)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] exp_word(input logic [31:0] cfg,
                                             input logic lvl, input logic sts);
        return (cfg & CFG_MASK) | (32'(lvl) << 16) | (32'(sts) << 28);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = AW'(addr);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] d);
        bus_addr = AW'(addr);
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, v);       chk("R1 pin0 word", v, 32'h0);
        rd(400, v);     chk("R1 pin100 word", v, 32'h0);
        rd(32'h2F8, v); chk("R1 summary lo", v, 32'h0);
        rd(32'h0FC, v); chk("R1 master", v, 32'h0);
        chk("R1 outputs", {31'b0, |{pin_out, pin_oe, irq}}, 32'h0);

        // R2 output value and enable
        wr(28, 32'h00C0_0000);
        chk("R2 pin_out7", {31'b0, pin_out[7]}, 32'h1);
        chk("R2 pin_oe7", {31'b0, pin_oe[7]}, 32'h1);
        rd(28, v); chk("R2 readback", v, 32'h00C0_0000);
        wr(28, 32'h0080_0000);
        chk("R2 pin_out7 low", {31'b0, pin_out[7]}, 32'h0);
        wr(28, 32'h0);

        // R2 random config write and readback (detect enable kept off)
        for (int k = 0; k < 30; k++) begin
            int p;
            logic [31:0] d;
            p = int'($urandom % NP);
            if (p == 63) p = 62;
            d = $urandom & ~32'h0000_0800;
            wr(p * 4, d);
            rd(p * 4, v);
            chk("R2 random readback", v, exp_word(d & ~32'h0000_0800, 1'b0, 1'b0));
            chk("R2 random drive", {30'b0, pin_oe[p], pin_out[p]}, {30'b0, d[23], d[22]});
            wr(p * 4, 32'h0);
        end

        // R3 synchroniser latency
        pin_in[5] = 1'b1;
        cyc(1); rd(20, v); chk("R3 after one edge", v, 32'h0);
        cyc(1); rd(20, v); chk("R3 after two edges", v, 32'h0001_0000);
        pin_in[5] = 1'b0;
        cyc(3);

        // R4 rising edge, R8 summary and irq timing
        wr(40, 32'h0000_1800);
        pin_in[10] = 1'b1;
        cyc(2);
        rd(40, v); chk("R4 status not yet", v & STS, 32'h0);
        cyc(1);
        rd(40, v); chk("R4 rising status", v, exp_word(32'h1800, 1'b1, 1'b1));
        chk("R8 irq not yet", {31'b0, irq}, 32'h0);
        rd(32'h2F8, v); chk("R8 summary group2", v, 32'h4);
        cyc(1);
        chk("R8 irq raised", {31'b0, irq}, 32'h1);

        // R9 end of interrupt with status still pending
        wr(32'h0FC, EOI);
        chk("R9 irq drop", {31'b0, irq}, 32'h0);
        cyc(1);
        chk("R9 irq re-rise", {31'b0, irq}, 32'h1);

        // R6 write-1-to-clear
        wr(40, 32'h0000_1800);
        rd(40, v); chk("R6 zero keeps status", v & STS, STS);
        wr(40, STS | 32'h0000_1800);
        rd(40, v); chk("R6 w1c clears", v & STS, 32'h0);
        rd(32'h2F8, v); chk("R9 summary empty", v, 32'h0);
        chk("R9 irq sticky", {31'b0, irq}, 32'h1);
        wr(32'h0FC, EOI);
        chk("R9 irq after eoi", {31'b0, irq}, 32'h0);
        cyc(1);
        chk("R9 irq stays low", {31'b0, irq}, 32'h0);

        // R4 falling input on rising config
        pin_in[10] = 1'b0;
        cyc(5);
        rd(40, v); chk("R4 rising ignores fall", v & STS, 32'h0);
        wr(40, 32'h0);

        // R4 falling-only
        wr(48, 32'h0000_1A00);
        pin_in[12] = 1'b1; cyc(5);
        rd(48, v); chk("R4 falling ignores rise", v & STS, 32'h0);
        pin_in[12] = 1'b0; cyc(5);
        rd(48, v); chk("R4 falling status", v & STS, STS);
        wr(48, STS);

        // R4 both edges
        wr(52, 32'h0000_1C00);
        pin_in[13] = 1'b1; cyc(5);
        rd(52, v); chk("R4 both rise", v & STS, STS);
        wr(52, STS | 32'h0000_1C00);
        pin_in[13] = 1'b0; cyc(5);
        rd(52, v); chk("R4 both fall", v & STS, STS);
        wr(52, STS);

        // R5 level active low, re-set while level persists
        wr(80, 32'h0000_1B00);
        cyc(1);
        rd(80, v); chk("R5 low level status", v & STS, STS);
        wr(80, STS | 32'h0000_1B00);
        rd(80, v); chk("R5 cleared", v & STS, 32'h0);
        cyc(1);
        rd(80, v); chk("R5 re-set", v & STS, STS);
        pin_in[20] = 1'b1; cyc(4);
        wr(80, STS | 32'h0000_1B00);
        cyc(1);
        rd(80, v); chk("R5 inactive stays clear", v & STS, 32'h0);
        wr(84, 32'h0000_1900);
        cyc(2);
        rd(84, v); chk("R5 active high idle", v & STS, 32'h0);
        wr(80, STS); wr(84, STS);
        wr(32'h0FC, EOI);
        cyc(1);
        chk("R9 idle irq", {31'b0, irq}, 32'h0);

        // R8 forward mask and detect enable
        wr(120, 32'h0000_0800);
        wr(124, 32'h0000_1000);
        pin_in[30] = 1'b1; pin_in[31] = 1'b1; cyc(5);
        rd(120, v); chk("R8 unforwarded status", v & STS, STS);
        rd(124, v); chk("R8 no detect enable", v & STS, 32'h0);
        rd(32'h2F8, v); chk("R8 masked summary", v, 32'h0);
        chk("R8 masked irq", {31'b0, irq}, 32'h0);
        wr(120, STS); wr(124, 32'h0);

        // R8 high summary word
        wr(720, 32'h0000_1800);
        pin_in[180] = 1'b1; cyc(5);
        rd(32'h2FC, v); chk("R8 summary hi bit13", v, 32'h0000_2000);
        chk("R8 irq from hi group", {31'b0, irq}, 32'h1);
        wr(720, STS); wr(32'h0FC, EOI);

        // R7 master slot and reserved pin
        wr(32'h0FC, 32'h00C0_1F00);
        rd(32'h0FC, v); chk("R7 master reads zero", v, 32'h0);
        chk("R7 pin63 drive", {30'b0, pin_oe[63], pin_out[63]}, 32'h0);
        pin_in[63] = 1'b1; cyc(5);
        pin_in[63] = 1'b0; cyc(5);
        rd(32'h2F8, v); chk("R7 group15 silent", v, 32'h0);
        chk("R7 irq silent", {31'b0, irq}, 32'h0);

        // R6 read-only and unused bits, unmapped offsets
        wr(160, 32'h00FF_00FF);
        rd(160, v); chk("R6 read-only ignored", v, 32'h00C0_0000);
        rd(32'h2F0, v); chk("R6 unmapped 0x2F0", v, 32'h0);
        rd(32'h3FC, v); chk("R6 unmapped 0x3FC", v, 32'h0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule